// File: doc/BRIEF.md
# Short-Vector Register Index Sequencer

This block sits between instruction decode and the single-precision arithmetic datapath. It takes one decoded arithmetic instruction and turns it into a run of per-element register operations. For each element it emits one destination and two source register numbers. The number of elements and the spacing between them come from a length field and a stride field in a 32-bit control word. Software writes that word through a simple write port and can read it back.

The 32 registers form four banks of eight. Bank 0 (registers 0–7) always works as scalar storage. The other banks rotate: as the sequence advances, each index steps by the stride modulo 8 and never leaves its own bank. If the destination lies in bank 0, or the instruction is a load or store, exactly one element is issued.

An element is handed over on every clock in which the consumer asserts `el_ready`. A new instruction is accepted only when the block is idle.

Top module: `svec_issue`

## Requirements
- R1: After reset the control word reads 0, `el_valid` is low and `ins_ready` is high.
- R2: A write with `ctl_we` high stores the whole 32-bit `ctl_wdata`, and `ctl_rdata` shows the stored value from the next cycle on.
- R3: Control bits 18:16 hold the vector length minus one. An arithmetic instruction whose destination is in banks 1–3 issues that many elements. `el_first` is high on the first element only and `el_last` on the last element only. A length field of 0 gives one element.
- R4: A destination in 0–7 issues exactly one element, with `el_first` and `el_last` both high, whatever the length field holds.
- R5: With `ins_mem` high, exactly one element is issued, whatever the length field holds.
- R6: Control bits 21:20 select the stride. The value 3 gives stride 2, and the values 0, 1 and 2 give stride 1.
- R7: The destination and any source outside bank 0 advance by the stride, modulo 8, in the low three index bits. Index bits 4:3 stay fixed for the whole sequence.
- R8: A source in 0–7 is repeated unchanged on every element.
- R9: One element is issued per clock while `el_ready` is high. While `el_ready` is low, the element is held stable. Acceptance makes `el_valid` high with `el_first` on the next cycle. `ins_ready` stays low from acceptance until the cycle after the last element is taken.
- R10: A control write made during an active sequence does not change that sequence. It applies from the next accepted instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Control word write enable |
| ctl_wdata | input | 32 | Control word write data |
| ctl_rdata | output | 32 | Control word read-back |
| ins_valid | input | 1 | Instruction offered |
| ins_ready | output | 1 | Block idle, can accept an instruction |
| ins_dst | input | 5 | Destination register number |
| ins_srca | input | 5 | First source register number |
| ins_srcb | input | 5 | Second source register number |
| ins_mem | input | 1 | Load/store instruction, never expanded |
| el_valid | output | 1 | Element tuple valid |
| el_ready | input | 1 | Consumer takes the element this cycle |
| el_dst | output | 5 | Element destination index |
| el_srca | output | 5 | Element first source index |
| el_srcb | output | 5 | Element second source index |
| el_first | output | 1 | First element of the instruction |
| el_last | output | 1 | Last element of the instruction |

## Verification
The assertions assume the consumer obeys the handshake. A raised `el_ready` counts only while `el_valid` is high, and instruction fields matter only in the cycle they are accepted. The stall property also assumes that no new instruction can appear while an element is pending. The bench changes inputs only on falling edges, holds `ins_valid` for a single accepted cycle, and drops `el_ready` only in the middle of a sequence. Control writes happen both while the block is idle and during a run, so the snapshot taken at acceptance can be told apart from the live register.

// File: rtl/svec_issue.sv
module svec_issue #(
  parameter int IDX_W   = 5,
  parameter int OFF_W   = 3,
  parameter int CTL_W   = 32,
  parameter int LEN_LSB = 16,
  parameter int STR_LSB = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  output logic [CTL_W-1:0] ctl_rdata,
  input  logic             ins_valid,
  output logic             ins_ready,
  input  logic [IDX_W-1:0] ins_dst,
  input  logic [IDX_W-1:0] ins_srca,
  input  logic [IDX_W-1:0] ins_srcb,
  input  logic             ins_mem,
  output logic             el_valid,
  input  logic             el_ready,
  output logic [IDX_W-1:0] el_dst,
  output logic [IDX_W-1:0] el_srca,
  output logic [IDX_W-1:0] el_srcb,
  output logic             el_first,
  output logic             el_last
);
  localparam int BANK_W = IDX_W - OFF_W;

  logic [CTL_W-1:0] ctl_q;
  logic             busy;
  logic [OFF_W-1:0] pos, lastpos, step;
  logic [IDX_W-1:0] d_q, a_q, b_q;

  wire take = ins_valid && !busy;
  wire fire = busy && el_ready;
  wire [OFF_W-1:0] len_m1 = ctl_q[LEN_LSB +: OFF_W];
  wire [1:0] sfld = ctl_q[STR_LSB +: 2];
  wire scalar = ins_mem || (ins_dst[IDX_W-1:OFF_W] == '0);

  function automatic logic [IDX_W-1:0] nxt(input logic [IDX_W-1:0] r, input logic [OFF_W-1:0] s);
    if (r[IDX_W-1:OFF_W] == '0) return r;
    return {r[IDX_W-1:OFF_W], r[OFF_W-1:0] + s};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q   <= '0;
      busy    <= 1'b0;
      pos     <= '0;
      lastpos <= '0;
      step    <= OFF_W'(1);
      d_q     <= '0;
      a_q     <= '0;
      b_q     <= '0;
    end else begin
      if (ctl_we) ctl_q <= ctl_wdata;
      if (take) begin
        busy    <= 1'b1;
        pos     <= '0;
        lastpos <= scalar ? '0 : len_m1;
        step    <= (sfld == 2'b11) ? OFF_W'(2) : OFF_W'(1);
        d_q     <= ins_dst;
        a_q     <= ins_srca;
        b_q     <= ins_srcb;
      end else if (fire) begin
        if (pos == lastpos) busy <= 1'b0;
        else begin
          pos <= pos + OFF_W'(1);
          d_q <= nxt(d_q, step);
          a_q <= nxt(a_q, step);
          b_q <= nxt(b_q, step);
        end
      end
    end
  end

  assign ctl_rdata = ctl_q;
  assign ins_ready = !busy;
  assign el_valid  = busy;
  assign el_dst    = d_q;
  assign el_srca   = a_q;
  assign el_srcb   = b_q;
  assign el_first  = busy && (pos == '0);
  assign el_last   = busy && (pos == lastpos);

  p_ctl_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |=> ctl_rdata == $past(ctl_wdata));
  p_scalar_dst_r4: assert property (@(posedge clk) disable iff (!rst_n)
    take && ins_dst[IDX_W-1:OFF_W] == '0 |=> el_valid && el_first && el_last);
  p_mem_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take && ins_mem |=> el_valid && el_last);
  p_bank_fixed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !el_last |=> el_valid && el_dst[IDX_W-1:OFF_W] == $past(el_dst[IDX_W-1:OFF_W])
      && el_srcb[IDX_W-1:OFF_W] == $past(el_srcb[IDX_W-1:OFF_W]));
  p_src_scalar_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !el_last && el_srca[IDX_W-1:OFF_W] == '0 |=> el_srca == $past(el_srca));
  p_accept_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid && ins_ready |=> el_valid && el_first);
  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    el_valid && !el_ready |=> el_valid && $stable(el_dst) && $stable(el_srca) && $stable(el_srcb)
      && $stable(el_first) && $stable(el_last));
  p_end_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    el_valid && el_ready && el_last |=> !el_valid && ins_ready);
  p_width_bank_r7: assert property (@(posedge clk) disable iff (!rst_n)
    BANK_W == 2);
endmodule

// File: tb/sim_svec_issue.sv
`timescale 1ns/1ps
module sim_svec_issue;
  logic clk = 0, rst_n = 0;
  logic ctl_we = 0;
  logic [31:0] ctl_wdata = 0, ctl_rdata;
  logic ins_valid = 0, ins_ready, ins_mem = 0;
  logic [4:0] ins_dst = 0, ins_srca = 0, ins_srcb = 0;
  logic el_valid, el_ready = 1, el_first, el_last;
  logic [4:0] el_dst, el_srca, el_srcb;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  svec_issue u0 (.clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .ins_valid(ins_valid), .ins_ready(ins_ready), .ins_dst(ins_dst),
    .ins_srca(ins_srca), .ins_srcb(ins_srcb), .ins_mem(ins_mem), .el_valid(el_valid),
    .el_ready(el_ready), .el_dst(el_dst), .el_srca(el_srca), .el_srcb(el_srcb),
    .el_first(el_first), .el_last(el_last));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] idx(input logic [4:0] r, input int k, input int s);
    if (r[4:3] == 2'b00) return r;
    return {r[4:3], 3'(int'(r[2:0]) + k * s)};
  endfunction

  task automatic wr_ctl(input logic [31:0] v);
    @(negedge clk); ctl_we = 1; ctl_wdata = v;
    @(negedge clk); ctl_we = 0;
  endtask

  task automatic issue(input logic [4:0] d, a, b, input bit mem);
    @(negedge clk);
    chk(ins_ready == 1, "R9 ready before issue", int'(ins_ready), 1);
    ins_valid = 1; ins_dst = d; ins_srca = a; ins_srcb = b; ins_mem = mem;
    @(negedge clk);
    ins_valid = 0; ins_mem = 0;
  endtask

  task automatic see(input int n, input int k, input logic [4:0] d, a, b, input int s, input string tag);
    chk(el_valid == 1, {tag, " valid"}, int'(el_valid), 1);
    chk(el_dst == idx(d, k, s), {tag, " dst"}, int'(el_dst), int'(idx(d, k, s)));
    chk(el_srca == idx(a, k, s), {tag, " srca"}, int'(el_srca), int'(idx(a, k, s)));
    chk(el_srcb == idx(b, k, s), {tag, " srcb"}, int'(el_srcb), int'(idx(b, k, s)));
    chk(el_first == (k == 0), {tag, " first"}, int'(el_first), int'(k == 0));
    chk(el_last == (k == n - 1), {tag, " last"}, int'(el_last), int'(k == n - 1));
    chk(ins_ready == 0, {tag, " ins_ready busy"}, int'(ins_ready), 0);
  endtask

  task automatic collect(input int n, input logic [4:0] d, a, b, input int s, input bit stall,
                         input bit wr_mid, input logic [31:0] wv, input string tag);
    for (int k = 0; k < n; k++) begin
      see(n, k, d, a, b, s, tag);
      if (stall && k == 1) begin
        el_ready = 0;
        @(negedge clk);
        see(n, k, d, a, b, s, {tag, " stalled"});
        el_ready = 1;
      end
      if (wr_mid && k == 1) begin ctl_we = 1; ctl_wdata = wv; end
      @(negedge clk);
      ctl_we = 0;
    end
    chk(el_valid == 0, {tag, " idle after last"}, int'(el_valid), 0);
    chk(ins_ready == 1, {tag, " ready after last"}, int'(ins_ready), 1);
  endtask

  task automatic t_reset;
    chk(ctl_rdata == 0, "R1 ctl reset", int'(ctl_rdata), 0);
    chk(el_valid == 0, "R1 el_valid reset", int'(el_valid), 0);
    chk(ins_ready == 1, "R1 ins_ready reset", int'(ins_ready), 1);
  endtask

  task automatic t_ctl;
    wr_ctl(32'hA5A5_1234);
    chk(ctl_rdata == 32'hA5A5_1234, "R2 readback", int'(ctl_rdata), int'(32'hA5A5_1234));
    wr_ctl(32'h0003_0000);
    chk(ctl_rdata == 32'h0003_0000, "R2 readback len4", int'(ctl_rdata), int'(32'h0003_0000));
  endtask

  task automatic t_vec4;
    issue(5'd8, 5'd8, 5'd16, 0);
    collect(4, 5'd8, 5'd8, 5'd16, 1, 0, 0, 0, "R3 len4");
  endtask

  task automatic t_wrap;
    issue(5'd14, 5'd22, 5'd30, 0);
    collect(4, 5'd14, 5'd22, 5'd30, 1, 0, 0, 0, "R7 wrap");
  endtask

  task automatic t_bank0;
    issue(5'd3, 5'd9, 5'd17, 0);
    collect(1, 5'd3, 5'd9, 5'd17, 1, 0, 0, 0, "R4 bank0 dst");
  endtask

  task automatic t_mem;
    issue(5'd8, 5'd8, 5'd16, 1);
    collect(1, 5'd8, 5'd8, 5'd16, 1, 0, 0, 0, "R5 load/store");
  endtask

  task automatic t_stride;
    wr_ctl(32'h0033_0000);
    issue(5'd8, 5'd17, 5'd29, 0);
    collect(4, 5'd8, 5'd17, 5'd29, 2, 0, 0, 0, "R6 stride2");
    wr_ctl(32'h0013_0000);
    issue(5'd8, 5'd17, 5'd29, 0);
    collect(4, 5'd8, 5'd17, 5'd29, 1, 0, 0, 0, "R6 reserved stride");
    wr_ctl(32'h0023_0000);
    issue(5'd24, 5'd16, 5'd8, 0);
    collect(4, 5'd24, 5'd16, 5'd8, 1, 0, 0, 0, "R6 reserved stride b");
  endtask

  task automatic t_scalar_src;
    wr_ctl(32'h0035_0000);
    issue(5'd16, 5'd2, 5'd24, 0);
    collect(6, 5'd16, 5'd2, 5'd24, 2, 0, 0, 0, "R8 scalar src");
  endtask

  task automatic t_stall;
    wr_ctl(32'h0003_0000);
    issue(5'd9, 5'd10, 5'd11, 0);
    collect(4, 5'd9, 5'd10, 5'd11, 1, 1, 0, 0, "R9 stall");
  endtask

  task automatic t_ctl_mid;
    issue(5'd8, 5'd16, 5'd24, 0);
    collect(4, 5'd8, 5'd16, 5'd24, 1, 0, 1, 32'h0000_0000, "R10 write mid");
    chk(ctl_rdata == 0, "R10 ctl updated", int'(ctl_rdata), 0);
    issue(5'd8, 5'd16, 5'd24, 0);
    collect(1, 5'd8, 5'd16, 5'd24, 1, 0, 0, 0, "R10 next uses new / R3 len1");
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_ctl;
    t_vec4;
    t_wrap;
    t_bank0;
    t_mem;
    t_stride;
    t_scalar_src;
    t_stall;
    t_ctl_mid;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule